// File: doc/BRIEF.md
# Error Code Queue with Event Strobes

This block keeps a first-in first-out list of signed error codes for a message-handling controller. Producers report each error as it is detected by raising a push strobe with a 16-bit signed code and a 2-bit class. The block stores the code and pulses the event strobe for that class for one cycle, so that a separate event register can latch the matching sticky bit. A consumer reads the oldest stored code from a combinational output and removes it with a pop strobe. A clear strobe empties the whole list.

Producers are never stalled, and there is no ready signal. A push arriving while the store is full is accepted at the port, but its code is not kept. Instead the most recent stored entry is overwritten with the overflow code -350. The oldest errors therefore survive, and the reader learns that errors were lost. The consumer may pop whenever it likes. Popping an empty store is harmless, and the output then shows 0, meaning no error.

Top module: `err_queue`

## Requirements
- R1: Stored codes are returned in the order they were pushed. `pop_code` shows the oldest stored code whenever the store is not empty.
- R2: A pop on a non-empty store removes the entry shown on `pop_code` at the clock edge. The next entry appears after that edge, and `count` drops by one.
- R3: While the store is empty, `pop_code` is 0. A pop in that state leaves `count` at 0.
- R4: A clear empties the store at the clock edge. It overrides any push or pop in the same cycle, and those are discarded.
- R5: The class encoding is 01 for a command error, 10 for an execution error and 11 for a device-dependent error. A push of class 01, 10 or 11 raises `evt_cmd`, `evt_exe` or `evt_dev` respectively, for exactly the one cycle after the push edge. This happens even when the code is dropped because the store is full or a clear is active.
- R6: A push of class 00 is ignored. No entry is stored and no event strobe rises.
- R7: When `count` equals DEPTH (default 16) and a push arrives without a pop, the push's own code is dropped. The newest stored entry becomes -350, the older entries are unchanged, and `count` stays at DEPTH.
- R8: A push and a pop in the same cycle are both honoured. On a non-empty store `count` is unchanged. On a full store the pushed code is stored normally. On an empty store the pop has no effect and the push is stored.
- R9: `count` gives the number of stored entries, from 0 to DEPTH. `empty` is high exactly when `count` is 0, and `not_empty` is its inverse. After reset the store is empty and every event strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Push strobe, accepted every cycle it is high |
| push_class | input | 2 | Error class: 01 command, 10 execution, 11 device-dependent, 00 ignored |
| push_code | input | 16 | Signed error code to store |
| pop | input | 1 | Removes the oldest entry at the clock edge |
| pop_code | output | 16 | Oldest stored code, or 0 when the store is empty |
| clear | input | 1 | Empties the store; overrides push and pop |
| empty | output | 1 | High when no entries are stored |
| not_empty | output | 1 | High when at least one entry is stored |
| count | output | 5 | Number of stored entries |
| evt_cmd | output | 1 | One-cycle strobe for a command-error push |
| evt_exe | output | 1 | One-cycle strobe for an execution-error push |
| evt_dev | output | 1 | One-cycle strobe for a device-dependent-error push |

## Verification
`count`, `empty`, `not_empty` and the event strobes are registered, so each is due in the cycle after the edge that captures a push, pop or clear. `pop_code` is combinational from the stored state, so it shows the new head in that same following cycle. The bench sets its inputs at a falling edge. At the next falling edge it compares every output with a queue model kept in the bench. Before each pop it first checks that `pop_code` shows the entry about to leave.

// File: rtl/errq_pkg.sv
package errq_pkg;
  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_CMD  = 2'b01,
    CLS_EXE  = 2'b10,
    CLS_DEV  = 2'b11
  } err_class_e;

  localparam int OVF_CODE_VALUE = -350;
endpackage

// File: rtl/errq_ctrl.sv
module errq_ctrl #(
  parameter int DEPTH = 16,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push_ok,
  input  logic            pop,
  input  logic            clear,
  output logic            wr_en,
  output logic            wr_ovf,
  output logic [AW-1:0]   wr_addr,
  output logic [AW-1:0]   rd_addr,
  output logic [CNTW-1:0] cnt
);
  localparam logic [AW-1:0]   LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

  logic [AW-1:0] wp, rp, wp_prev;
  logic full, emp, do_pop, do_push, do_ovw;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == FULL_CNT);
  assign emp     = (cnt == '0);
  assign do_pop  = pop && !emp && !clear;
  assign do_push = push_ok && !clear && (!full || do_pop);
  assign do_ovw  = push_ok && !clear && full && !do_pop;
  assign wp_prev = (wp == '0) ? LAST_IDX : wp - 1'b1;

  assign wr_en   = do_push || do_ovw;
  assign wr_ovf  = do_ovw;
  assign wr_addr = do_ovw ? wp_prev : wp;
  assign rd_addr = rp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else if (clear) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= adv(wp);
      if (do_pop)  rp <= adv(rp);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);
  assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_ok && !pop && !clear) |=> (cnt == FULL_CNT));
  assert_empty_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (emp && pop && !push_ok && !clear) |=> (cnt == '0));
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt == '0));
  assert_pushpop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!emp && pop && push_ok && !clear) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/errq_store.sv
module errq_store #(
  parameter int DEPTH = 16,
  parameter int CW    = 16,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic                 wr_ovf,
  input  logic [AW-1:0]        wr_addr,
  input  logic signed [CW-1:0] wr_code,
  input  logic [AW-1:0]        rd_addr,
  output logic signed [CW-1:0] rd_code
);
  localparam logic signed [CW-1:0] OVF_CODE = CW'(errq_pkg::OVF_CODE_VALUE);

  logic signed [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_ovf ? OVF_CODE : wr_code;
  end

  assign rd_code = mem[rd_addr];
endmodule

// File: rtl/errq_events.sv
module errq_events (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_valid,
  input  errq_pkg::err_class_e     push_class,
  output logic                     evt_cmd,
  output logic                     evt_exe,
  output logic                     evt_dev
);
  import errq_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_cmd <= 1'b0;
      evt_exe <= 1'b0;
      evt_dev <= 1'b0;
    end else begin
      evt_cmd <= push_valid && (push_class == CLS_CMD);
      evt_exe <= push_valid && (push_class == CLS_EXE);
      evt_dev <= push_valid && (push_class == CLS_DEV);
    end
  end

  assert_evt_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_cmd, evt_exe, evt_dev}));
  assert_evt_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_class == CLS_CMD) |=> evt_cmd);
  assert_evt_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!push_valid || push_class == CLS_NONE) |=> !(evt_cmd || evt_exe || evt_dev));
endmodule

// File: rtl/err_queue.sv
module err_queue #(
  parameter int DEPTH = 16,
  parameter int CW    = 16,
  parameter int CNTW  = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push_valid,
  input  logic [1:0]           push_class,
  input  logic signed [CW-1:0] push_code,
  input  logic                 pop,
  output logic signed [CW-1:0] pop_code,
  input  logic                 clear,
  output logic                 empty,
  output logic                 not_empty,
  output logic [CNTW-1:0]      count,
  output logic                 evt_cmd,
  output logic                 evt_exe,
  output logic                 evt_dev
);
  import errq_pkg::*;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  err_class_e           cls;
  logic                 push_ok, wr_en, wr_ovf;
  logic [AW-1:0]        wr_addr, rd_addr;
  logic signed [CW-1:0] head;

  assign cls     = err_class_e'(push_class);
  assign push_ok = push_valid && (cls != CLS_NONE);

  errq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CNTW(CNTW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .push_ok(push_ok), .pop(pop), .clear(clear),
    .wr_en(wr_en), .wr_ovf(wr_ovf), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .cnt(count)
  );

  errq_store #(.DEPTH(DEPTH), .CW(CW), .AW(AW)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_ovf(wr_ovf), .wr_addr(wr_addr),
    .wr_code(push_code), .rd_addr(rd_addr), .rd_code(head)
  );

  errq_events u_events (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_class(cls),
    .evt_cmd(evt_cmd), .evt_exe(evt_exe), .evt_dev(evt_dev)
  );

  assign empty     = (count == '0);
  assign not_empty = !empty;
  assign pop_code  = empty ? '0 : head;

  assert_empty_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (pop_code == '0));
  assert_class_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_class == 2'b00 && !pop && !clear) |=> $stable(count));
endmodule

// File: tb/err_queue_tb.sv
`timescale 1ns/1ps
module err_queue_tb;
  localparam int DEPTH = 16;
  localparam int CNTW  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push_valid = 1'b0;
  logic [1:0] push_class = 2'b00;
  logic signed [15:0] push_code = '0;
  logic pop = 1'b0;
  logic clear = 1'b0;
  logic signed [15:0] pop_code;
  logic empty, not_empty;
  logic [CNTW-1:0] count;
  logic evt_cmd, evt_exe, evt_dev;

  int checks = 0;
  int errors = 0;
  int mq[$];
  logic [2:0] exp_evt = 3'b000;
  bit done = 0;

  always #4 clk = ~clk;

  err_queue #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_class(push_class),
    .push_code(push_code), .pop(pop), .pop_code(pop_code), .clear(clear),
    .empty(empty), .not_empty(not_empty), .count(count),
    .evt_cmd(evt_cmd), .evt_exe(evt_exe), .evt_dev(evt_dev)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] evt_of(input bit p, input logic [1:0] c);
    if (!p) return 3'b000;
    case (c)
      2'b01: return 3'b001;
      2'b10: return 3'b010;
      2'b11: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic check_state();
    chk("R9", "count", int'(count), mq.size());
    chk("R9", "empty", int'(empty), (mq.size() == 0) ? 1 : 0);
    chk("R9", "not_empty", int'(not_empty), (mq.size() != 0) ? 1 : 0);
    chk("R5", "events", int'({evt_dev, evt_exe, evt_cmd}), int'(exp_evt));
    chk(mq.size() ? "R1" : "R3", "pop_code", int'(pop_code), mq.size() ? mq[0] : 0);
  endtask

  task automatic step(input bit p, input logic [1:0] c, input int code, input bit po, input bit cl);
    @(negedge clk);
    check_state();
    push_valid = p; push_class = c; push_code = 16'(code); pop = po; clear = cl;
    exp_evt = evt_of(p, c);
    if (cl) mq.delete();
    else begin
      if (po && mq.size() > 0) void'(mq.pop_front());
      if (p && c != 2'b00) begin
        if (mq.size() < DEPTH) mq.push_back(code);
        else mq[mq.size() - 1] = -350;
      end
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state, R9 and R3
    step(0, 2'b00, 0, 0, 0);
    // pop on empty: R3
    step(0, 2'b00, 0, 1, 0);
    step(0, 2'b00, 0, 1, 0);
    // ordered pushes with each class: R1 R5
    step(1, 2'b01, -101, 0, 0);
    step(1, 2'b10, -222, 0, 0);
    step(1, 2'b11, -333, 0, 0);
    // class 00 ignored: R6
    step(1, 2'b00, -7, 0, 0);
    // pops in order: R2
    step(0, 2'b00, 0, 1, 0);
    step(0, 2'b00, 0, 1, 0);
    step(0, 2'b00, 0, 1, 0);
    // push+pop on empty: R8
    step(1, 2'b01, -1, 1, 0);
    // fill past capacity: R7
    for (int i = 0; i < DEPTH + 2; i++) step(1, 2'b10, -200 - i, 0, 0);
    // push+pop on full: R8
    step(1, 2'b11, -999, 1, 0);
    // overflow again then drain: R7 R1
    step(1, 2'b01, -500, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 2'b00, 0, 1, 0);
    // clear beats push and pop: R4
    step(1, 2'b11, -42, 1, 1);
    step(0, 2'b00, 0, 0, 0);
    // random phase
    for (int i = 0; i < 5000; i++) begin
      int phase = (i / 250) % 3;
      int r = int'($urandom_range(99, 0));
      bit p  = (phase == 0) ? (r < 80) : (phase == 1) ? (r < 30) : (r < 50);
      bit po = (int'($urandom_range(99, 0)) < ((phase == 0) ? 20 : (phase == 1) ? 70 : 50));
      bit cl = (int'($urandom_range(999, 0)) < 4);
      logic [1:0] c = 2'($urandom_range(3, 0));
      int code = -int'($urandom_range(400, 1));
      step(p, c, code, po, cl);
    end
    step(0, 2'b00, 0, 0, 0);
    @(negedge clk);
    check_state();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule